// File: doc/BRIEF.md
# SPI Client with Address Filtering

This block is the client side of a serial peripheral interface link. An external host drives the serial clock, the data line into the block and an active-low select. The block shifts bytes in and out in any of the four clock polarity and phase combinations, with either bit order. All three pins pass through synchronizers into the system clock domain, so the serial clock must run well below the system clock.

Received bytes land in a one-byte buffer. The buffer raises a one-cycle strobe when a byte arrives and stays full until the consumer reads it. A byte that arrives while the buffer is full is lost and sets a sticky overflow status. A configuration bit chooses whether that status rises at the moment of the loss or later, when the consumer reads the byte that sits ahead of the lost one. Bytes to send are written into a holding register and picked up at the start of each byte. In the optional address frame format, the first byte of every select period is compared against a programmable address under a care mask, and the later bytes of that period are accepted only if the comparison matched.

Top module: `spi_client_addr`

## Requirements
- R1: Bits are sampled on the rising serial clock edge when {cfg_cpol, cfg_cpha} is 0 or 3, and on the falling edge when it is 1 or 2. When cfg_lsb_first is 0 the first received bit is bit 7 of the byte. When it is 1 the first received bit is bit 0.
- R2: miso presents the outgoing byte one bit per serial clock, in the order set by cfg_lsb_first, and changes only on the non-sampling edge. When cfg_cpha is 0, the first bit is already present once select goes active. miso is 1 while select is inactive.
- R3: The outgoing byte is taken from the holding register (written by tx_load with tx_data) when select goes active and when each byte completes. If the holding register is empty at that moment, 8'hFF is sent.
- R4: An accepted byte appears on rx_data with a one-cycle rx_strobe. rx_valid then stays 1 until rx_read is pulsed.
- R5: When cfg_frame is 4'h2, the first byte after select goes active is not delivered. It is compared with cfg_addr on the bits where cfg_addr_care is 1. addr_match shows the result until select goes inactive, and the later bytes of that select period are delivered only when it is 1.
- R6: Every cfg_frame value other than 4'h2 behaves as a plain frame, in which every byte is delivered.
- R7: When select goes inactive, a partially shifted byte is discarded, and the next select period starts again with the address byte.
- R8: With cfg_ovf_immediate set to 1, a byte that arrives while rx_valid is 1 is dropped and ovf_status rises in the next cycle. rx_data keeps the older byte.
- R9: With cfg_ovf_immediate set to 0, the drop leaves ovf_status at 0 until rx_read removes the older byte. ovf_status rises in the cycle after that read.
- R10: ovf_status stays 1 until ovf_clear is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| cfg_lsb_first | input | 1 | Bit order for both directions |
| cfg_frame | input | 4 | Frame format; 4'h2 selects address frames |
| cfg_addr | input | 8 | Address compared with the first byte |
| cfg_addr_care | input | 8 | Bits of the address that take part in the comparison |
| cfg_ovf_immediate | input | 1 | Overflow status timing choice |
| tx_data | input | 8 | Byte to send |
| tx_load | input | 1 | Writes tx_data into the holding register |
| rx_read | input | 1 | Consumer read; empties the buffer |
| ovf_clear | input | 1 | Clears ovf_status |
| rx_data | output | 8 | Last accepted byte |
| rx_valid | output | 1 | Buffer holds an unread byte |
| rx_strobe | output | 1 | One-cycle pulse per accepted byte |
| addr_match | output | 1 | The address byte of this select period matched |
| ovf_status | output | 1 | Sticky overflow flag |

## Verification
The bench exercises all four clock modes with both bit orders, and captures miso just before each sampling edge. If the sampling edges were swapped, or the first bit were late when cfg_cpha is 0, the received byte and the returned byte would come out shifted. It stops select in the middle of a byte and in the middle of an address frame. A design that kept the partial bits or the address state would then deliver a garbled byte, or would deliver the next address byte as data. It forces overflows under both timing choices and checks ovf_status before and after the read. This catches a flag that rises too early, a flag that never rises, and a flag that clears by itself. It also checks that the masked address comparison ignores the bits marked don't-care, and that the reserved frame codes deliver every byte.

// File: rtl/spi_client_pkg.sv
package spi_client_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CNT_W   = $clog2(BYTE_W);
  localparam int unsigned FRAME_W = 4;
  localparam logic [FRAME_W-1:0] FRAME_ADDR = 4'h2;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // bit sent at position idx of a byte in the chosen order
  function automatic logic pick_bit(input byte_t d, input cnt_t idx, input logic lsb);
    return lsb ? d[idx] : d[cnt_t'(BYTE_W-1) - idx];
  endfunction

  // append one received bit in the chosen order
  function automatic byte_t shift_in(input byte_t d, input logic b, input logic lsb);
    return lsb ? {b, d[BYTE_W-1:1]} : {d[BYTE_W-2:0], b};
  endfunction

  // modes 0 and 3 sample on the rising edge
  function automatic logic samples_on_rise(input logic cpol, input logic cpha);
    return cpol == cpha;
  endfunction

  function automatic logic addr_hit(input byte_t rx, input byte_t a, input byte_t care);
    return ((rx ^ a) & care) == '0;
  endfunction

  function automatic logic is_addr_frame(input logic [FRAME_W-1:0] f);
    return f == FRAME_ADDR;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic cs_n,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_on,
  output logic sel_start
);
  localparam int unsigned NPINS = 3;
  localparam int unsigned CHAIN = STAGES * NPINS;

  logic [NPINS-1:0] raw;
  logic [NPINS-1:0] synced;
  logic [CHAIN-1:0] chain;
  logic             sck_prev;
  logic             sel_prev;

  assign raw = {sck, mosi, ~cs_n};

  if (STAGES > 1) begin : g_multi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[CHAIN-NPINS-1:0], raw};
    end
  end else begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= raw;
    end
  end

  assign synced = chain[CHAIN-1 -: NPINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      sel_prev <= 1'b0;
    end else begin
      sck_prev <= synced[2];
      sel_prev <= synced[0];
    end
  end

  assign mosi_s    = synced[1];
  assign sel_on    = synced[0];
  assign sel_start = synced[0] & ~sel_prev;
  assign sck_rise  = synced[2] & ~sck_prev;
  assign sck_fall  = ~synced[2] & sck_prev;
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_client_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mosi_s,
  input  logic  sck_rise,
  input  logic  sck_fall,
  input  logic  sel_on,
  input  logic  sel_start,
  input  logic  cfg_cpol,
  input  logic  cfg_cpha,
  input  logic  cfg_lsb_first,
  input  byte_t tx_data,
  input  logic  tx_load,
  output logic  miso,
  output logic  sample_evt,
  output logic  change_evt,
  output logic  byte_done,
  output byte_t byte_val
);
  cnt_t  bit_cnt;
  byte_t rx_sh;
  byte_t tx_sh;
  byte_t hold;
  logic  hold_full;
  logic  miso_q;
  logic  on_rise;
  logic  last_bit;
  logic  consume;
  byte_t next_tx;

  assign on_rise    = samples_on_rise(cfg_cpol, cfg_cpha);
  assign sample_evt = sel_on & (on_rise ? sck_rise : sck_fall);
  assign change_evt = sel_on & (on_rise ? sck_fall : sck_rise);
  assign last_bit   = bit_cnt == cnt_t'(BYTE_W-1);
  assign byte_done  = sample_evt & last_bit;
  assign byte_val   = shift_in(rx_sh, mosi_s, cfg_lsb_first);
  assign consume    = sel_start | byte_done;
  assign next_tx    = hold_full ? hold : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (!sel_on) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (sample_evt) begin
      rx_sh   <= byte_val;
      bit_cnt <= last_bit ? '0 : bit_cnt + cnt_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
      tx_sh     <= '1;
    end else begin
      if (consume) tx_sh <= next_tx;
      if (tx_load) begin
        hold      <= tx_data;
        hold_full <= 1'b1;
      end else if (consume) begin
        hold_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          miso_q <= 1'b1;
    else if (sel_start)  miso_q <= pick_bit(next_tx, '0, cfg_lsb_first);
    else if (change_evt) miso_q <= pick_bit(tx_sh, bit_cnt, cfg_lsb_first);
  end

  assign miso = sel_on ? miso_q : 1'b1;
endmodule

// File: rtl/spi_rx_filter.sv
module spi_rx_filter
  import spi_client_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_on,
  input  logic               byte_done,
  input  byte_t              byte_val,
  input  logic [FRAME_W-1:0] cfg_frame,
  input  byte_t              cfg_addr,
  input  byte_t              cfg_addr_care,
  input  logic               cfg_ovf_immediate,
  input  logic               rx_read,
  input  logic               ovf_clear,
  output byte_t              rx_data,
  output logic               rx_valid,
  output logic               rx_strobe,
  output logic               addr_match,
  output logic               ovf_status,
  output logic               ovf_evt
);
  logic addr_mode;
  logic first_pending;
  logic addr_phase;
  logic accept;
  logic store;
  logic lost_pending;
  logic ovf_set;

  assign addr_mode  = is_addr_frame(cfg_frame);
  assign addr_phase = addr_mode & first_pending;
  assign accept     = byte_done & ~addr_phase & (~addr_mode | addr_match);
  assign ovf_evt    = accept & rx_valid & ~rx_read;
  assign store      = accept & ~ovf_evt;
  assign ovf_set    = (ovf_evt & cfg_ovf_immediate) | (rx_read & lost_pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_pending <= 1'b1;
      addr_match    <= 1'b0;
    end else if (!sel_on) begin
      first_pending <= 1'b1;
      addr_match    <= 1'b0;
    end else if (byte_done && addr_phase) begin
      first_pending <= 1'b0;
      addr_match    <= addr_hit(byte_val, cfg_addr, cfg_addr_care);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      rx_strobe <= 1'b0;
    end else begin
      rx_strobe <= store;
      if (store) begin
        rx_data  <= byte_val;
        rx_valid <= 1'b1;
      end else if (rx_read) begin
        rx_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_pending <= 1'b0;
      ovf_status   <= 1'b0;
    end else begin
      if (ovf_evt && !cfg_ovf_immediate) lost_pending <= 1'b1;
      else if (rx_read)                  lost_pending <= 1'b0;
      if (ovf_set)        ovf_status <= 1'b1;
      else if (ovf_clear) ovf_status <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_client_addr.sv
module spi_client_addr
  import spi_client_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck,
  input  logic               cs_n,
  input  logic               mosi,
  output logic               miso,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic               cfg_lsb_first,
  input  logic [FRAME_W-1:0] cfg_frame,
  input  logic [BYTE_W-1:0]  cfg_addr,
  input  logic [BYTE_W-1:0]  cfg_addr_care,
  input  logic               cfg_ovf_immediate,
  input  logic [BYTE_W-1:0]  tx_data,
  input  logic               tx_load,
  input  logic               rx_read,
  input  logic               ovf_clear,
  output logic [BYTE_W-1:0]  rx_data,
  output logic               rx_valid,
  output logic               rx_strobe,
  output logic               addr_match,
  output logic               ovf_status
);
  // named internal events, observed by the bound checker
  logic  mosi_s;
  logic  sck_rise;
  logic  sck_fall;
  logic  sel_on;
  logic  sel_start;
  logic  sample_evt;
  logic  change_evt;
  logic  byte_done;
  byte_t byte_val;
  logic  ovf_evt;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (sck),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .mosi_s    (mosi_s),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .sel_on    (sel_on),
    .sel_start (sel_start)
  );

  spi_shift_core u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .mosi_s        (mosi_s),
    .sck_rise      (sck_rise),
    .sck_fall      (sck_fall),
    .sel_on        (sel_on),
    .sel_start     (sel_start),
    .cfg_cpol      (cfg_cpol),
    .cfg_cpha      (cfg_cpha),
    .cfg_lsb_first (cfg_lsb_first),
    .tx_data       (tx_data),
    .tx_load       (tx_load),
    .miso          (miso),
    .sample_evt    (sample_evt),
    .change_evt    (change_evt),
    .byte_done     (byte_done),
    .byte_val      (byte_val)
  );

  spi_rx_filter u_filt (
    .clk               (clk),
    .rst_n             (rst_n),
    .sel_on            (sel_on),
    .byte_done         (byte_done),
    .byte_val          (byte_val),
    .cfg_frame         (cfg_frame),
    .cfg_addr          (cfg_addr),
    .cfg_addr_care     (cfg_addr_care),
    .cfg_ovf_immediate (cfg_ovf_immediate),
    .rx_read           (rx_read),
    .ovf_clear         (ovf_clear),
    .rx_data           (rx_data),
    .rx_valid          (rx_valid),
    .rx_strobe         (rx_strobe),
    .addr_match        (addr_match),
    .ovf_status        (ovf_status),
    .ovf_evt           (ovf_evt)
  );
endmodule

// File: rtl/spi_client_chk.sv
module spi_client_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_on,
  input logic       miso,
  input logic       sample_evt,
  input logic       change_evt,
  input logic       byte_done,
  input logic       ovf_evt,
  input logic       cfg_ovf_immediate,
  input logic [3:0] cfg_frame,
  input logic       rx_strobe,
  input logic       rx_valid,
  input logic       rx_read,
  input logic       addr_match,
  input logic       ovf_status,
  input logic       ovf_clear
);
  AST_DONE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> sample_evt); // R1
  AST_ONE_EDGE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_evt, change_evt})); // R1
  AST_MISO_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_on |-> miso); // R2
  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_read |=> rx_valid); // R4
  AST_STROBE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe && cfg_frame == 4'h2 |-> addr_match); // R5
  AST_IMMEDIATE_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && cfg_ovf_immediate |=> ovf_status); // R8
  AST_DEFERRED_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !cfg_ovf_immediate && !ovf_status |=> !ovf_status); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_status && !ovf_clear |=> ovf_status); // R10
endmodule

bind spi_client_addr spi_client_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .sel_on            (sel_on),
  .miso              (miso),
  .sample_evt        (sample_evt),
  .change_evt        (change_evt),
  .byte_done         (byte_done),
  .ovf_evt           (ovf_evt),
  .cfg_ovf_immediate (cfg_ovf_immediate),
  .cfg_frame         (cfg_frame),
  .rx_strobe         (rx_strobe),
  .rx_valid          (rx_valid),
  .rx_read           (rx_read),
  .addr_match        (addr_match),
  .ovf_status        (ovf_status),
  .ovf_clear         (ovf_clear)
);

// File: tb/sim_spi_client_addr.sv
module sim_spi_client_addr;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, lsb = 1'b0, imm = 1'b1;
  logic [3:0] frame = 4'h0;
  logic [7:0] addr = 8'h00, care = 8'hFF, tx_data = 8'h00;
  logic tx_load = 1'b0, man_read = 1'b0, mon_read = 1'b0, ovf_clear = 1'b0;
  logic rx_read, miso, rx_valid, rx_strobe, addr_match, ovf_status;
  logic [7:0] rx_data;
  bit auto_read = 1'b1;
  string cur_tag = "R4";
  int vectors = 0, fails = 0;
  logic [7:0] exp_q[$];

  assign rx_read = man_read | mon_read;
  always #10 clk = ~clk;

  spi_client_addr u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_lsb_first(lsb), .cfg_frame(frame),
    .cfg_addr(addr), .cfg_addr_care(care), .cfg_ovf_immediate(imm),
    .tx_data(tx_data), .tx_load(tx_load), .rx_read(rx_read), .ovf_clear(ovf_clear),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_strobe(rx_strobe),
    .addr_match(addr_match), .ovf_status(ovf_status)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic expect_rx(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  task automatic sel_begin();
    sck = cpol;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic sel_end();
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(2*H);
  endtask

  // drives nbits of mo; captures miso just before each sampling edge
  task automatic xfer(input logic [7:0] mo, input int nbits, input logic [7:0] exp_miso,
                      input bit chk, input string tag);
    logic [7:0] got = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      int idx = lsb ? i : 7 - i;
      if (!cpha) begin
        mosi = mo[idx];
        wait_clk(H);
        got[idx] = miso;
        sck = ~sck;
        wait_clk(H);
        sck = ~sck;
      end else begin
        sck = ~sck;
        mosi = mo[idx];
        wait_clk(H);
        got[idx] = miso;
        sck = ~sck;
        wait_clk(H);
      end
    end
    if (chk) check(got == exp_miso, tag, got, exp_miso);
  endtask

  task automatic pulse_read();
    @(negedge clk); man_read = 1'b1;
    @(negedge clk); man_read = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); ovf_clear = 1'b1;
    @(negedge clk); ovf_clear = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_strobe) begin
      if (exp_q.size() == 0) begin
        check(1'b0, {cur_tag, " unexpected byte"}, rx_data, 32'hFFFF);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rx_data == e, cur_tag, rx_data, e);
      end
      mon_read = auto_read;
    end else begin
      mon_read = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    check(rx_valid == 1'b0, "R4 reset valid", rx_valid, 0);
    check(ovf_status == 1'b0, "R10 reset ovf", ovf_status, 0);
    check(miso == 1'b1, "R2 idle miso", miso, 1);
    check(addr_match == 1'b0, "R5 reset match", addr_match, 0);

    // R1 R2 R3: mode 0, MSB first, then empty holding register
    cur_tag = "R1 mode0 rx";
    put_tx(8'hA5);
    sel_begin();
    expect_rx(8'h3C);
    xfer(8'h3C, 8, 8'hA5, 1'b1, "R2 mode0 miso");
    expect_rx(8'hC3);
    xfer(8'hC3, 8, 8'hFF, 1'b1, "R3 empty hold sends FF");
    sel_end();
    check(exp_q.size() == 0, "R1 mode0 drained", exp_q.size(), 0);

    // R1 R2: modes 1..3, LSB first on modes 2 and 3
    for (int m = 1; m < 4; m++) begin
      cpol = m[1]; cpha = m[0]; lsb = (m != 1);
      cur_tag = "R1 mode rx";
      put_tx(8'h4E ^ 8'(m));
      sel_begin();
      expect_rx(8'h96 ^ 8'(m << 4));
      xfer(8'h96 ^ 8'(m << 4), 8, 8'h4E ^ 8'(m), 1'b1, "R2 mode miso");
      sel_end();
      check(exp_q.size() == 0, "R1 mode drained", exp_q.size(), 0);
    end

    // R5: address frame, match
    cpol = 0; cpha = 0; lsb = 0; frame = 4'h2; addr = 8'h5A; care = 8'hFF;
    cur_tag = "R5 addressed";
    sel_begin();
    xfer(8'h5A, 8, 8'h00, 1'b0, "");
    check(addr_match == 1'b1, "R5 match flag", addr_match, 1);
    expect_rx(8'h11); xfer(8'h11, 8, 8'h00, 1'b0, "");
    expect_rx(8'h22); xfer(8'h22, 8, 8'h00, 1'b0, "");
    sel_end();
    check(addr_match == 1'b0, "R7 match cleared", addr_match, 0);
    // R5: mismatch gates the rest
    sel_begin();
    xfer(8'h5B, 8, 8'h00, 1'b0, "");
    check(addr_match == 1'b0, "R5 mismatch flag", addr_match, 0);
    xfer(8'h33, 8, 8'h00, 1'b0, "");
    sel_end();
    // R5: care mask ignores low nibble
    addr = 8'h50; care = 8'hF0;
    sel_begin();
    xfer(8'h5F, 8, 8'h00, 1'b0, "");
    check(addr_match == 1'b1, "R5 masked match", addr_match, 1);
    expect_rx(8'h44); xfer(8'h44, 8, 8'h00, 1'b0, "");
    sel_end();
    check(exp_q.size() == 0, "R5 drained", exp_q.size(), 0);

    // R6: reserved code behaves as plain
    frame = 4'h7; cur_tag = "R6 reserved code";
    sel_begin();
    expect_rx(8'h5A); xfer(8'h5A, 8, 8'h00, 1'b0, "");
    expect_rx(8'h66); xfer(8'h66, 8, 8'h00, 1'b0, "");
    sel_end();
    check(exp_q.size() == 0, "R6 drained", exp_q.size(), 0);

    // R7: partial byte discarded
    frame = 4'h0; cur_tag = "R7 partial";
    sel_begin(); xfer(8'hAB, 4, 8'h00, 1'b0, ""); sel_end();
    sel_begin(); expect_rx(8'h0F); xfer(8'h0F, 8, 8'h00, 1'b0, ""); sel_end();
    // R7: address phase restarts
    frame = 4'h2; addr = 8'h5A; care = 8'hFF; cur_tag = "R7 addr restart";
    sel_begin(); xfer(8'h5A, 8, 8'h00, 1'b0, ""); xfer(8'h77, 3, 8'h00, 1'b0, ""); sel_end();
    sel_begin(); xfer(8'h5A, 8, 8'h00, 1'b0, "");
    expect_rx(8'h78); xfer(8'h78, 8, 8'h00, 1'b0, ""); sel_end();
    check(exp_q.size() == 0, "R7 drained", exp_q.size(), 0);

    // R8: immediate overflow
    frame = 4'h0; auto_read = 1'b0; imm = 1'b1; cur_tag = "R8 first byte";
    sel_begin();
    expect_rx(8'h21); xfer(8'h21, 8, 8'h00, 1'b0, "");
    check(ovf_status == 1'b0, "R8 no ovf yet", ovf_status, 0);
    xfer(8'h42, 8, 8'h00, 1'b0, "");
    check(ovf_status == 1'b1, "R8 immediate ovf", ovf_status, 1);
    check(rx_data == 8'h21, "R8 older byte kept", rx_data, 8'h21);
    sel_end();
    pulse_read();
    wait_clk(4);
    check(ovf_status == 1'b1, "R10 sticky after read", ovf_status, 1);
    pulse_clear();
    check(ovf_status == 1'b0, "R10 cleared", ovf_status, 0);

    // R9: in-stream overflow
    imm = 1'b0; cur_tag = "R9 first byte";
    sel_begin();
    expect_rx(8'h31); xfer(8'h31, 8, 8'h00, 1'b0, "");
    xfer(8'h62, 8, 8'h00, 1'b0, "");
    sel_end();
    check(ovf_status == 1'b0, "R9 deferred", ovf_status, 0);
    check(rx_data == 8'h31, "R9 older byte kept", rx_data, 8'h31);
    pulse_read();
    check(ovf_status == 1'b1, "R9 set on read", ovf_status, 1);
    check(rx_valid == 1'b0, "R4 read empties", rx_valid, 0);
    pulse_clear();
    check(ovf_status == 1'b0, "R10 cleared again", ovf_status, 0);
    check(exp_q.size() == 0, "R4 all delivered", exp_q.size(), 0);

    summary();
  end
endmodule